// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

This block is a 36-bit first-in first-out buffer with a write side and a read side that run on separate free-running clocks. The two clocks may be unrelated, or they may be the same net. The depth is a power-of-two parameter between 2048 and 8192 words. The storage is an inferred dual-clock RAM. Each pointer crosses to the other clock domain as a Gray code through a two-flop synchronizer. Full and almost-full are worked out on the write side, and empty and almost-empty on the read side.

A strap sampled during master reset selects one of two read disciplines:
- **Standard mode**: the read status flag means "empty", and a word appears on `rdata` one read-clock cycle after a read is requested.
- **Fall-through mode**: the read status flag means "output ready", and the oldest word sits on `rdata` before any request is made.

A second strap picks one of five preset level offsets for the almost flags. The offsets can be rewritten afterwards, either as a parallel word or as a serial bit stream. Master reset empties the buffer and re-latches both straps. Partial reset empties it but keeps the mode and the current offsets. A retransmit pulse sends the read pointer back to where it stood at the last reset.

The read side is a small state machine with three states:
- **RS_DIRECT** is used in standard mode. It never leaves this state, and a read is issued on each request while data is stored.
- **RS_VOID** is the fall-through state with no word presented. It moves to RS_HOLD by fetching a word as soon as the memory holds one.
- **RS_HOLD** is the fall-through state with a word presented. A request consumes the word: if more data is stored it fetches the next word and stays in RS_HOLD, and if the memory is empty it moves to RS_VOID. A retransmit moves it to RS_VOID.

Reset puts the machine in RS_DIRECT or RS_VOID, as the latched mode selects.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave in the order they were accepted, bit-exact over 36 bits. The clocks are independent, and writes and reads on the same edge are both accepted.
- R2: In standard mode (`fwft_strap`=0 at master reset), `rd_stat`=1 means no word is stored. A read request (`ren`=1 at a rising `rclk` edge while `rd_stat`=0) puts the word on `rdata` after that edge.
- R3: In fall-through mode (`fwft_strap`=1), `rd_stat`=1 means the oldest word is on `rdata` without any request. `ren`=1 at an edge consumes that word. While `ren`=0, the word and the flag hold.
- R4: `wr_stat` is the full flag in standard mode (1 when DEPTH words are held). In fall-through mode it is input-ready, the inverse of full.
- R5: A write while full and a read while empty (or, in fall-through mode, while not ready) are ignored, and no pointer moves.
- R6: At master reset, `preset_sel` values 0, 1, 2, 3 set both offsets to 8, 16, 64 and 256 words. Any value of 4 or more sets them to 1024.
- R7: Once the pointers have crossed, `almost_empty`=1 exactly when the words in memory are at or below the empty offset. `almost_full`=1 exactly when they are at or above DEPTH minus the full offset. A word presented in fall-through mode no longer counts.
- R8: `ld_en`=1 at a `wclk` edge loads `ld_val` into the empty offset when `ld_sel`=0, or into the full offset when `ld_sel`=1.
- R9: Each `wclk` edge with `ser_en`=1 and `ld_en`=0 shifts in `ser_bit`. After 2·log2(DEPTH) bits, the empty offset holds the first half (MSB first) and the full offset holds the second half.
- R10: Either reset, held for at least three edges of both clocks, empties the buffer. Master reset also re-latches the mode and the preset. Partial reset keeps both, including any programmed offsets. Offset programming is ignored while either reset is active.
- R11: An `rt` pulse at an `rclk` edge rewinds reading to the first word accepted since the last reset, provided no more than DEPTH words were written since then. A `ren` on the same edge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low |
| prst_n | input | 1 | Partial reset, active low |
| fwft_strap | input | 1 | Mode strap: 0 standard, 1 fall-through |
| preset_sel | input | 3 | Offset preset strap |
| wen | input | 1 | Write request |
| wdata | input | DW | Write data |
| wr_stat | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_full | output | 1 | Almost-full level flag |
| ren | input | 1 | Read request |
| rt | input | 1 | Retransmit pulse |
| rdata | output | DW | Read data |
| rd_stat | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Almost-empty level flag |
| ld_en | input | 1 | Parallel offset load strobe |
| ld_sel | input | 1 | Parallel target: 0 empty offset, 1 full offset |
| ld_val | input | log2(DEPTH) | Parallel offset value |
| ser_en | input | 1 | Serial offset shift enable |
| ser_bit | input | 1 | Serial offset data bit |

## Verification
The hardest situation to reach is a completely full buffer whose flags have settled while the other side keeps poking it. Writes into a full buffer and reads from an empty one must leave both pointers untouched, and that only shows once every stored word is later read back intact. The stimulus reaches it with directed fills of exactly DEPTH words while the reader is held off, followed by extra write attempts and a full drain. Randomly throttled writer and reader processes on the two unrelated clocks then drive the empty and full boundaries many times over in both modes. Retransmit and the partial reset that keeps programmed offsets are each reached by directed sequences built on those fills.

// File: rtl/xcf_pkg.sv
`timescale 1ns/1ps
package xcf_pkg;

    typedef enum logic [1:0] {
        RS_DIRECT,
        RS_VOID,
        RS_HOLD
    } rd_state_e;

    function automatic int unsigned preset_words(input logic [2:0] sel);
        case (sel)
            3'd0:    return 8;
            3'd1:    return 16;
            3'd2:    return 64;
            3'd3:    return 256;
            default: return 1024;
        endcase
    endfunction

endpackage

// File: rtl/xcf_gray_sync.sv
`timescale 1ns/1ps
module xcf_gray_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    always_comb begin
        logic acc;
        acc = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            acc        = acc ^ sync_q[i];
            bin_out[i] = acc;
        end
    end
endmodule

// File: rtl/xcf_cfg.sv
`timescale 1ns/1ps
module xcf_cfg
    import xcf_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          hold,
    input  logic [2:0]    preset_sel,
    input  logic          ld_en,
    input  logic          ld_sel,
    input  logic [AW-1:0] ld_val,
    input  logic          ser_en,
    input  logic          ser_bit,
    output logic [AW-1:0] ae_off,
    output logic [AW-1:0] af_off
);
    always_ff @(posedge clk) begin
        if (mrst) begin
            ae_off <= AW'(preset_words(preset_sel));
            af_off <= AW'(preset_words(preset_sel));
        end else if (!hold) begin
            if (ld_en) begin
                if (ld_sel) af_off <= ld_val;
                else        ae_off <= ld_val;
            end else if (ser_en) begin
                {ae_off, af_off} <= {ae_off[AW-2:0], af_off, ser_bit};
            end
        end
    end
endmodule

// File: rtl/xcf_rd_ctrl.sv
`timescale 1ns/1ps
module xcf_rd_ctrl
    import xcf_pkg::*;
#(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fwft,
    input  logic          ren,
    input  logic          rt,
    input  logic [PW-1:0] wbin_s,
    output logic [PW-1:0] rbin,
    output logic          ram_rd,
    output logic          rd_stat,
    output logic          mem_empty
);
    rd_state_e state, nxt;

    assign mem_empty = (rbin == wbin_s);

    always_ff @(posedge clk) begin
        if (rst) state <= fwft ? RS_VOID : RS_DIRECT;
        else     state <= nxt;
    end

    always_comb begin
        nxt     = state;
        ram_rd  = 1'b0;
        rd_stat = 1'b0;
        unique case (state)
            RS_DIRECT: begin
                rd_stat = mem_empty;
                ram_rd  = ren && !mem_empty && !rt;
            end
            RS_VOID: begin
                if (!rt && !mem_empty) begin
                    ram_rd = 1'b1;
                    nxt    = RS_HOLD;
                end
            end
            RS_HOLD: begin
                rd_stat = 1'b1;
                if (rt) begin
                    nxt = RS_VOID;
                end else if (ren) begin
                    if (!mem_empty) ram_rd = 1'b1;
                    else            nxt    = RS_VOID;
                end
            end
            default: nxt = RS_DIRECT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || rt)   rbin <= '0;
        else if (ram_rd) rbin <= rbin + PW'(1);
    end
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
    parameter int DEPTH = 2048,
    parameter int DW    = 36
) (
    input  logic                     wclk,
    input  logic                     rclk,
    input  logic                     mrst_n,
    input  logic                     prst_n,
    input  logic                     fwft_strap,
    input  logic [2:0]               preset_sel,
    input  logic                     wen,
    input  logic [DW-1:0]            wdata,
    output logic                     wr_stat,
    output logic                     almost_full,
    input  logic                     ren,
    input  logic                     rt,
    output logic [DW-1:0]            rdata,
    output logic                     rd_stat,
    output logic                     almost_empty,
    input  logic                     ld_en,
    input  logic                     ld_sel,
    input  logic [$clog2(DEPTH)-1:0] ld_val,
    input  logic                     ser_en,
    input  logic                     ser_bit
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic          mrst, rst_any;
    logic          fwft_w, fwft_r;
    logic [PW-1:0] wbin, wgray, rbin, rgray, wbin_s, rbin_s, wcount, rcount;
    logic [AW-1:0] ae_off, af_off;
    logic          full, mem_empty, ram_rd, wr_go;
    logic [DW-1:0] ram_q;
    logic [DW-1:0] mem [DEPTH];

    assign mrst    = !mrst_n;
    assign rst_any = !mrst_n || !prst_n;

    always_ff @(posedge wclk) if (mrst) fwft_w <= fwft_strap;
    always_ff @(posedge rclk) if (mrst) fwft_r <= fwft_strap;

    xcf_cfg #(.AW(AW)) u_cfg (
        .clk(wclk), .mrst(mrst), .hold(rst_any), .preset_sel(preset_sel),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val),
        .ser_en(ser_en), .ser_bit(ser_bit), .ae_off(ae_off), .af_off(af_off)
    );

    // write domain
    assign wcount      = wbin - rbin_s;
    assign full        = (wcount == PW'(DEPTH));
    assign wr_go       = wen && !full && !rst_any;
    assign wr_stat     = fwft_w ? !full : full;
    assign almost_full = (wcount >= (PW'(DEPTH) - PW'(af_off)));

    always_ff @(posedge wclk) begin
        if (rst_any) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            if (wr_go) wbin <= wbin + PW'(1);
            wgray <= wbin ^ (wbin >> 1);
        end
    end

    always_ff @(posedge wclk) begin
        if (wr_go) mem[wbin[AW-1:0]] <= wdata;
    end

    xcf_gray_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst(rst_any), .gray_in(rgray), .bin_out(rbin_s)
    );

    // read domain
    xcf_gray_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst(rst_any), .gray_in(wgray), .bin_out(wbin_s)
    );

    xcf_rd_ctrl #(.PW(PW)) u_rd (
        .clk(rclk), .rst(rst_any), .fwft(fwft_r), .ren(ren), .rt(rt),
        .wbin_s(wbin_s), .rbin(rbin), .ram_rd(ram_rd),
        .rd_stat(rd_stat), .mem_empty(mem_empty)
    );

    always_ff @(posedge rclk) begin
        if (rst_any) rgray <= '0;
        else         rgray <= rbin ^ (rbin >> 1);
    end

    always_ff @(posedge rclk) begin
        if (ram_rd) ram_q <= mem[rbin[AW-1:0]];
    end

    assign rdata        = ram_q;
    assign rcount       = wbin_s - rbin;
    assign almost_empty = (rcount <= PW'(ae_off));
endmodule

// File: rtl/xcf_chk.sv
`timescale 1ns/1ps
module xcf_chk #(
    parameter int PW = 12,
    parameter int DW = 36
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_any,
    input logic          wen,
    input logic          full,
    input logic          almost_full,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rbin,
    input logic          mem_empty,
    input logic          almost_empty,
    input logic          rt,
    input logic          ren,
    input logic          fwft_r,
    input logic          rd_stat,
    input logic [DW-1:0] rdata
);
    AST_FULL_BLOCKS_WRITE: assert property (@(posedge wclk) disable iff (rst_any) full && wen |=> $stable(wbin)); // R5
    AST_EMPTY_BLOCKS_READ: assert property (@(posedge rclk) disable iff (rst_any) mem_empty && !rt |=> $stable(rbin)); // R5
    AST_FULL_IS_ALMOST: assert property (@(posedge wclk) disable iff (rst_any) full |-> almost_full); // R7
    AST_EMPTY_IS_ALMOST: assert property (@(posedge rclk) disable iff (rst_any) mem_empty |-> almost_empty); // R7
    AST_FWFT_WORD_HOLDS: assert property (@(posedge rclk) disable iff (rst_any) fwft_r && rd_stat && !ren && !rt |=> rd_stat && $stable(rdata)); // R3
    AST_GRAY_ONE_BIT: assert property (@(posedge wclk) disable iff (rst_any) $onehot0(wgray ^ $past(wgray))); // R1
    AST_RT_REWINDS: assert property (@(posedge rclk) disable iff (rst_any) rt |=> (rbin == '0)); // R11
endmodule

bind xclk_fifo xcf_chk #(.PW(PW), .DW(DW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_any(rst_any), .wen(wen), .full(full),
    .almost_full(almost_full), .wbin(wbin), .wgray(wgray), .rbin(rbin),
    .mem_empty(mem_empty), .almost_empty(almost_empty), .rt(rt), .ren(ren),
    .fwft_r(fwft_r), .rd_stat(rd_stat), .rdata(rdata)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
    localparam int DEPTH = 2048;
    localparam int DW    = 36;
    localparam int AW    = $clog2(DEPTH);

    logic wclk = 0, rclk = 0;
    logic mrst_n = 0, prst_n = 1, fwft_strap = 0;
    logic [2:0] preset_sel = 0;
    logic wen = 0, ren = 0, rt = 0, ld_en = 0, ld_sel = 0, ser_en = 0, ser_bit = 0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] ld_val = '0;
    logic wr_stat, almost_full, rd_stat, almost_empty;
    logic [DW-1:0] rdata;

    int checks = 0, errors = 0;
    bit fwft_m = 0;
    int ae_m = 8, af_m = 8;
    logic [DW-1:0] q[$];
    logic [DW-1:0] hist[$];

    always #2.5 wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    xclk_fifo #(.DEPTH(DEPTH), .DW(DW)) u_xclk_fifo (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .fwft_strap(fwft_strap), .preset_sel(preset_sel),
        .wen(wen), .wdata(wdata), .wr_stat(wr_stat), .almost_full(almost_full),
        .ren(ren), .rt(rt), .rdata(rdata), .rd_stat(rd_stat), .almost_empty(almost_empty),
        .ld_en(ld_en), .ld_sel(ld_sel), .ld_val(ld_val), .ser_en(ser_en), .ser_bit(ser_bit)
    );

    function automatic int preset_of(input int sel);
        case (sel)
            0: return 8;
            1: return 16;
            2: return 64;
            3: return 256;
            default: return 1024;
        endcase
    endfunction

    function automatic int mem_words();
        if (fwft_m && q.size() > 0) return q.size() - 1;
        return q.size();
    endfunction

    function automatic logic ae_expect();
        return logic'(mem_words() <= ae_m);
    endfunction

    function automatic logic af_expect();
        return logic'(mem_words() >= DEPTH - af_m);
    endfunction

    function automatic logic [DW-1:0] rnd_word();
        return {4'($urandom()), $urandom()};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge wclk);
        repeat (8) @(negedge rclk);
    endtask

    task automatic writer(input int n, input int pct);
        int got = 0;
        while (got < n) begin
            @(negedge wclk);
            wen   = (int'($urandom_range(99, 0)) < pct);
            wdata = rnd_word();
            if (wen && !(fwft_m ? !wr_stat : wr_stat)) begin
                q.push_back(wdata);
                hist.push_back(wdata);
                got++;
            end
        end
        @(negedge wclk);
        wen = 0;
    endtask

    task automatic reader(input int n, input int pct);
        int got = 0;
        bit pend = 0;
        logic [DW-1:0] exp_v = '0;
        while (got < n) begin
            @(negedge rclk);
            if (pend) begin
                check("R2 standard read data", rdata, exp_v);
                pend = 0;
            end
            ren = 0;
            if (!fwft_m) begin
                if (!rd_stat && int'($urandom_range(99, 0)) < pct) begin
                    if (q.size() == 0) check("R5 read with nothing stored", 1, 0);
                    else begin
                        ren = 1; exp_v = q.pop_front(); pend = 1; got++;
                    end
                end
            end else if (rd_stat) begin
                if (q.size() == 0) check("R5 ready with nothing stored", 1, 0);
                else begin
                    check("R3 fall-through word", rdata, q[0]);
                    if (int'($urandom_range(99, 0)) < pct) begin
                        ren = 1; void'(q.pop_front()); got++;
                    end
                end
            end
        end
        @(negedge rclk);
        ren = 0;
        if (pend) check("R2 standard read data", rdata, exp_v);
    endtask

    task automatic do_mrst(input bit mode, input int sel);
        wen = 0; ren = 0; rt = 0; ld_en = 0; ser_en = 0;
        fwft_strap = mode; preset_sel = 3'(sel); mrst_n = 0;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        mrst_n = 1;
        fwft_m = mode; ae_m = preset_of(sel); af_m = ae_m;
        q.delete(); hist.delete();
        settle();
    endtask

    task automatic do_prst(input bit poke);
        wen = 0; ren = 0; rt = 0;
        prst_n = 0;
        repeat (2) @(negedge wclk);
        if (poke) begin
            ld_en = 1; ld_sel = 0; ld_val = AW'(7);
            @(negedge wclk);
            ld_en = 0;
        end
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        prst_n = 1;
        q.delete(); hist.delete();
        settle();
    endtask

    task automatic par_load(input bit sel, input int val);
        @(negedge wclk);
        ld_en = 1; ld_sel = sel; ld_val = AW'(val);
        @(negedge wclk);
        ld_en = 0;
        if (sel) af_m = val; else ae_m = val;
    endtask

    task automatic ser_load(input int ae_v, input int af_v);
        logic [2*AW-1:0] vec;
        vec = {AW'(ae_v), AW'(af_v)};
        for (int i = 2 * AW - 1; i >= 0; i--) begin
            @(negedge wclk);
            ser_en = 1; ser_bit = vec[i];
        end
        @(negedge wclk);
        ser_en = 0;
        ae_m = ae_v; af_m = af_v;
    endtask

    task automatic retransmit();
        @(negedge rclk);
        rt = 1;
        @(negedge rclk);
        rt = 0;
        q = hist;
    endtask

    task automatic check_levels(input string tag);
        settle();
        check({tag, " almost-empty"}, almost_empty, ae_expect());
        check({tag, " almost-full"}, almost_full, af_expect());
    endtask

    initial begin
        #900000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int sels[4] = '{2, 3, 4, 7};
        void'($urandom(32'd20240611));

        // standard mode, preset 8
        do_mrst(0, 0);
        check("R10 reset rd_stat empty", rd_stat, 1);
        check("R4 reset wr_stat not full", wr_stat, 0);
        check("R10 reset almost-empty", almost_empty, 1);
        check("R10 reset almost-full", almost_full, 0);

        writer(8, 100);  check_levels("R6 preset 8 at offset");
        writer(1, 100);  check_levels("R6 preset 8 above offset");
        reader(9, 100);
        settle();
        check("R2 empty after drain", rd_stat, 1);

        // reads on empty ignored
        @(negedge rclk); ren = 1;
        repeat (3) @(negedge rclk);
        ren = 0;
        writer(1, 100);
        settle();
        reader(1, 100);  // R5 pointer unchanged: the fresh word comes out

        // R6 remaining presets
        foreach (sels[k]) begin
            do_mrst(0, sels[k]);
            writer(preset_of(sels[k]), 100); check_levels("R6 preset at offset");
            writer(1, 100);                  check_levels("R6 preset above offset");
            reader(q.size(), 100);
        end

        // R8 parallel load, then fill to full
        do_mrst(0, 0);
        par_load(0, 3);
        writer(3, 100);  check_levels("R8 loaded empty offset at 3");
        writer(1, 100);  check_levels("R8 loaded empty offset above");
        reader(4, 100);
        par_load(1, 100);
        writer(DEPTH - 100, 100); check_levels("R8 loaded full offset at");
        reader(1, 100);           check_levels("R8 loaded full offset below");
        writer(101, 100);
        settle();
        check("R4 full flag at DEPTH", wr_stat, 1);
        check("R7 almost-full at DEPTH", almost_full, 1);
        @(negedge wclk); wen = 1; wdata = '1;
        repeat (5) @(negedge wclk);
        wen = 0;
        reader(DEPTH, 100);  // R5 extra writes must not appear
        settle();
        check("R5 empty after full drain", rd_stat, 1);

        // R9 serial load
        ser_load(5, 20);
        writer(5, 100);  check_levels("R9 serial empty offset at 5");
        writer(1, 100);  check_levels("R9 serial empty offset above");
        writer(DEPTH - 26, 100); check_levels("R9 serial full offset at");

        // R10 partial reset keeps offsets, ignores programming
        do_prst(1);
        check("R10 partial reset empties", rd_stat, 1);
        writer(5, 100);  check_levels("R10 kept empty offset at 5");
        writer(1, 100);  check_levels("R10 kept empty offset above");
        reader(6, 100);

        // R11 retransmit, standard mode
        do_prst(0);
        writer(10, 100);
        reader(10, 100);
        settle();
        retransmit();
        settle();
        check("R11 data back after rewind", rd_stat, 0);
        reader(10, 100);
        settle();
        check("R11 empty after replay", rd_stat, 1);

        // fall-through mode, preset 16
        do_mrst(1, 1);
        check("R3 reset not ready", rd_stat, 0);
        check("R4 reset input ready", wr_stat, 1);
        writer(17, 100);
        settle();
        check("R3 word presented without request", rd_stat, 1);
        check("R3 first word on output", rdata, q[0]);
        check_levels("R6 preset 16 at offset");
        writer(1, 100);  check_levels("R7 fall-through above offset");
        reader(18, 100);
        settle();
        check("R3 not ready after drain", rd_stat, 0);

        // R11 retransmit, fall-through mode
        do_prst(0);
        writer(6, 100);
        reader(6, 100);
        settle();
        retransmit();
        settle();
        check("R11 fall-through replay ready", rd_stat, 1);
        reader(6, 100);

        // R1 random traffic in both modes
        do_mrst(0, 2);
        fork
            writer(3000, 70);
            reader(3000, 55);
        join
        do_mrst(1, 3);
        fork
            writer(3000, 40);
            reader(3000, 90);
        join
        do_mrst(1, 0);
        fork
            writer(2500, 95);
            reader(2500, 30);
        join
        settle();
        check("R1 all words delivered", 36'(q.size()), 36'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule